// File: doc/BRIEF.md
# Prescaled Compare-Match Sync Pulse Timer

This block is a free-running timer that turns a fast system clock into a periodic sync pulse, such as the line or frame sync of a raster display. A power-of-two prescaler sets the timer tick. A counter runs from zero up to a programmable top value and then wraps. A second programmable value sets how many ticks, counted from the wrap, the pulse stays in its active level.

An invert control selects the pulse style. In clear-on-match style the pin is high from the wrap until the width value is matched, then low for the rest of the period. In set-on-match style the pin has the opposite levels. Each wrap raises a single-clock overflow strobe.

Top and width values are captured into working registers only at a wrap. Software can rewrite them at any time without cutting short the period in progress.

Some example settings:
- At a 16 MHz clock, a divide of 8 with top 63 and width 7 gives a 32 µs line with a 4 µs pulse.
- A divide of 1024 with top 259 and width 0 gives a frame of about 16.64 ms with one 64 µs pulse.

Top module: `sync_pulse_timer`

## Requirements
- R1: While reset is held, and until the first tick afterwards, the counter is zero. During that time `ovf_o` is 0 and `sync_o` is at its active level. The active level is 1 when `invert_i`=0 and 0 when `invert_i`=1.
- R2: `presc_sel_i` gives the base-2 log of the clock divide: code s divides by 2^s, for s from 0 to 10. Any code above 10 acts as 10. The prescaler is cleared by reset, so the first tick falls on the 2^s-th rising edge after reset is released.
- R3: The counter counts ticks from 0 to `top_i` inclusive and then wraps to 0, so a period is (`top_i`+1)·2^s clocks. `ovf_o` is high for exactly the one clock that follows each wrapping edge, which is once per period.
- R4: With `invert_i`=0, `sync_o` is 1 while the count is at most `width_i`, which is (`width_i`+1) ticks from the wrap. It is 0 for the rest of the period.
- R5: With `invert_i`=1, `sync_o` is the complement of the R4 level.
- R6: When `width_i` is greater than or equal to `top_i`, `sync_o` stays at its active level for the whole period. This includes the case `top_i`=0, where `ovf_o` is high on every tick.
- R7: Values on `top_i` and `width_i` are sampled into the working registers at the first clock after reset and at each wrap. A change between wraps has no effect until the next wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| presc_sel_i | input | 4 | Base-2 log of the clock divide, clamped to 10 |
| top_i | input | 16 | Zero-relative period value, in ticks |
| width_i | input | 16 | Zero-relative pulse width, in ticks |
| invert_i | input | 1 | 0: active-high pulse (clear on match), 1: active-low pulse (set on match) |
| sync_o | output | 1 | Sync pulse pin |
| ovf_o | output | 1 | One-clock strobe after each wrap |

## Verification
The hardest case to reach is a rewrite of the compare values in the middle of a period. Such a rewrite must not be visible until the next wrap. The bench changes the top and width values a few ticks after a wrap. It then looks at cycles where the old and new values give different answers: a wrap that only the old top would produce, and a pulse level that only the new width would give. Large-divide settings, including a select code above the clamp, run for full periods so that the tick spacing is measured rather than assumed.

// File: rtl/spt_pkg.sv
package spt_pkg;
   // Clamp a requested prescale shift to the largest one built.
   function automatic int unsigned clamp_shift(int unsigned req, int unsigned max_sh);
      return (req > max_sh) ? max_sh : req;
   endfunction
endpackage

// File: rtl/spt_prescaler.sv
module spt_prescaler #(
   parameter int MAX_SHIFT = 10,
   parameter int SEL_W     = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int PRE_W = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
   localparam int SH_W  = $clog2(MAX_SHIFT + 1) > 0 ? $clog2(MAX_SHIFT + 1) : 1;

   logic [PRE_W-1:0]   pre_q;
   logic [MAX_SHIFT:0] tick_opt;
   logic [SH_W-1:0]    shift_eff;

   always_ff @(posedge clk_i) begin
      if (rst_i) pre_q <= '0;
      else       pre_q <= pre_q + 1'b1;
   end

   // One candidate tick per divide ratio: all low bits at one.
   for (genvar k = 0; k <= MAX_SHIFT; k++) begin : g_opt
      if (k == 0) begin : g_div1
         assign tick_opt[k] = 1'b1;
      end else begin : g_divn
         assign tick_opt[k] = &pre_q[k-1:0];
      end
   end

   always_comb begin
      shift_eff = SH_W'(spt_pkg::clamp_shift(int'(unsigned'(sel_i)), MAX_SHIFT));
      tick_o    = tick_opt[shift_eff];
   end
endmodule

// File: rtl/spt_counter.sv
module spt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] top_i,
   input  logic [CNT_W-1:0] width_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] top_o,
   output logic [CNT_W-1:0] width_o,
   output logic             loaded_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q, top_act, wid_act;
   logic             loaded_q, wrap_q;
   logic [CNT_W-1:0] top_eff, wid_eff;

   // Before the first capture the live inputs stand in for the working values.
   always_comb begin
      top_eff = loaded_q ? top_act : top_i;
      wid_eff = loaded_q ? wid_act : width_i;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q    <= '0;
         top_act  <= '0;
         wid_act  <= '0;
         loaded_q <= 1'b0;
         wrap_q   <= 1'b0;
      end else begin
         wrap_q <= 1'b0;
         if (!loaded_q) begin
            loaded_q <= 1'b1;
            top_act  <= top_i;
            wid_act  <= width_i;
         end
         if (tick_i) begin
            if (cnt_q == top_eff) begin
               cnt_q   <= '0;
               top_act <= top_i;
               wid_act <= width_i;
               wrap_q  <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o    = cnt_q;
   assign top_o    = top_eff;
   assign width_o  = wid_eff;
   assign loaded_o = loaded_q;
   assign wrap_o   = wrap_q;
endmodule

// File: rtl/spt_outcmp.sv
module spt_outcmp #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] width_i,
   input  logic             invert_i,
   output logic             sync_o
);
   logic active;
   always_comb begin
      active = (cnt_i <= width_i);
      sync_o = active ^ invert_i;
   end
endmodule

// File: rtl/sync_pulse_timer.sv
module sync_pulse_timer #(
   parameter int CNT_W     = 16,
   parameter int MAX_SHIFT = 10,
   parameter int SEL_W     = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [SEL_W-1:0] presc_sel_i,
   input  logic [CNT_W-1:0] top_i,
   input  logic [CNT_W-1:0] width_i,
   input  logic             invert_i,
   output logic             sync_o,
   output logic             ovf_o
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (MAX_SHIFT < 0 || MAX_SHIFT > 30) begin : g_bad_shift
      $error("MAX_SHIFT must lie in 0..30");
   end
   if ((2 ** SEL_W) <= MAX_SHIFT) begin : g_bad_sel
      $error("SEL_W too narrow to code MAX_SHIFT");
   end

   logic             tick;
   logic [CNT_W-1:0] cnt_q, top_act, wid_act;
   logic             loaded;

   spt_prescaler #(.MAX_SHIFT(MAX_SHIFT), .SEL_W(SEL_W)) u_pre (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .sel_i (presc_sel_i),
      .tick_o(tick)
   );

   spt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .tick_i  (tick),
      .top_i   (top_i),
      .width_i (width_i),
      .cnt_o   (cnt_q),
      .top_o   (top_act),
      .width_o (wid_act),
      .loaded_o(loaded),
      .wrap_o  (ovf_o)
   );

   spt_outcmp #(.CNT_W(CNT_W)) u_cmp (
      .cnt_i   (cnt_q),
      .width_i (wid_act),
      .invert_i(invert_i),
      .sync_o  (sync_o)
   );
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] top_act,
   input logic             loaded,
   input logic             invert,
   input logic             sync,
   input logic             ovf
);
   // R3: the counter never passes the working top value
   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
      loaded |-> cnt <= top_act);

   // R3: the overflow strobe always coincides with a zero count
   p_ovf_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
      ovf |-> cnt == '0);

   // R2: the count moves only after a prescaler tick
   p_cnt_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt));

   // R7: the working top value changes only at a wrap
   p_top_held_r7: assert property (@(posedge clk) disable iff (rst)
      (!ovf && $past(loaded)) |-> $stable(top_act));

   // R4 and R5: the start of every period shows the active level
   p_active_at_wrap_r4: assert property (@(posedge clk) disable iff (rst)
      ovf |-> sync == ~invert);
endmodule

bind sync_pulse_timer spt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk_i),
   .rst    (rst_i),
   .tick   (tick),
   .cnt    (cnt_q),
   .top_act(top_act),
   .loaded (loaded),
   .invert (invert_i),
   .sync   (sync_o),
   .ovf    (ovf_o)
);

// File: tb/tb_sync_pulse_timer.sv
`timescale 1ns/1ps
module tb_sync_pulse_timer;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  sel = '0;
   logic [15:0] top = '0;
   logic [15:0] wid = '0;
   logic        inv = 1'b0;
   logic        sync, ovf;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   sync_pulse_timer dut (
      .clk_i(clk), .rst_i(rst), .presc_sel_i(sel), .top_i(top),
      .width_i(wid), .invert_i(inv), .sync_o(sync), .ovf_o(ovf)
   );

   // Columns: select code, top, width, invert, edges to run
   localparam int NV = 8;
   localparam int VEC [NV][5] = '{
      '{3,  63, 7, 0, 1100},  // R3 R4: divide 8 line timing
      '{10, 3,  0, 0, 8300},  // R2: divide 1024
      '{0,  4,  1, 1, 30},    // R5: inverted, divide 1
      '{2,  5,  5, 0, 60},    // R6: width equal to top
      '{1,  3,  9, 1, 30},    // R6 R5: width above top
      '{15, 1,  0, 1, 8300},  // R2: select above the clamp
      '{0,  0,  0, 0, 10},    // R6: top zero
      '{4,  6,  2, 0, 250}    // R3 R4
   };

   function automatic int eff_shift(int s);
      return (s > 10) ? 10 : s;
   endfunction

   function automatic logic e_sync(int n, int s, int t, int w, int p);
      int c;
      c = (n >> eff_shift(s)) % (t + 1);
      return logic'((c <= w) ? 1 : 0) ^ logic'(p);
   endfunction

   function automatic logic e_ovf(int n, int s, int t);
      return (n > 0) && ((n % ((t + 1) << eff_shift(s))) == 0);
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // Hold reset over a few edges, then release at a falling edge.
   task automatic do_reset(int s, int t, int w, int p);
      @(negedge clk);
      rst = 1'b1;
      sel = 4'(s); top = 16'(t); wid = 16'(w); inv = p[0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      // Vector walk: every edge compared with the model, one check per row.
      for (int r = 0; r < NV; r++) begin
         int bad;
         do_reset(VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3]);
         bad = 0;
         for (int n = 0; n <= VEC[r][4]; n++) begin
            logic es, eo;
            if (n > 0) step();
            es = e_sync(n, VEC[r][0], VEC[r][1], VEC[r][2], VEC[r][3]);
            eo = e_ovf(n, VEC[r][0], VEC[r][1]);
            if (bad == 0 && (sync !== es || ovf !== eo)) begin
               bad = 1;
               $display("FAIL R3 R4 R5 R6 row %0d edge %0d sync=%b/%b ovf=%b/%b (actual/expected)",
                        r, n, sync, es, ovf, eo);
            end
         end
         checks++;
         if (bad != 0) fails++;
      end

      // R1: reset state for both polarities, including a reset mid-run
      do_reset(0, 5, 1, 1);
      repeat (4) step();
      @(negedge clk); rst = 1'b1;
      step();
      chk("R1 sync in reset, inverted", sync, 1'b0);
      chk("R1 ovf in reset", ovf, 1'b0);
      inv = 1'b0;
      #1;
      chk("R1 sync in reset, non-inverted", sync, 1'b1);

      // R2: first tick after release lands on edge 8 for divide 8
      do_reset(3, 7, 0, 0);
      repeat (7) step();
      chk("R2 no tick before edge 8", sync, 1'b1);
      step();
      chk("R2 tick at edge 8", sync, 1'b0);

      // R7: rewrite top and width two edges into a period
      do_reset(0, 3, 1, 0);
      repeat (2) step();
      top = 16'd9; wid = 16'd4;
      step();  // edge 3: count 3, old width 1 gives low
      chk("R7 old width kept before wrap", sync, 1'b0);
      step();  // edge 4: wrap by old top
      chk("R7 wrap on old top", ovf, 1'b1);
      repeat (4) step();  // edge 8: count 4
      chk("R7 no wrap at old period", ovf, 1'b0);
      chk("R7 new width after wrap", sync, 1'b1);
      step();  // edge 9: count 5
      chk("R7 new width ends", sync, 1'b0);
      repeat (5) step();  // edge 14
      chk("R7 wrap on new top", ovf, 1'b1);
      step();
      chk("R3 strobe lasts one clock", ovf, 1'b0);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule